// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit adds or subtracts two 32-bit words. It can treat each word as four independent 8-bit lanes or as two independent 16-bit lanes. Each lane clamps to its representable range instead of wrapping. Clamping is unsigned, to the range 0 to all-ones, or signed, to the most negative and most positive two's-complement values. A third size setting selects a single full-width signed addition. That addition wraps, and it only reports overflow.

Every accepted operation registers its packed result and a per-lane clamp vector one cycle later, together with an output valid strobe. Any lane clamp or any full-width overflow sets a sticky overflow flag. The flag stays set until an explicit clear or a reset. A datapath uses the unit by presenting operands and control together with `in_valid_i`. The result is then collected on `out_valid_o`.

Top module: `psat_unit`

## Requirements
- R1: `size_sel_i` picks the lane layout. Code 0 gives four 8-bit lanes, with lane k at bits [8k+7:8k]. Code 1 gives two 16-bit lanes, with lane k at bits [16k+15:16k]. Codes 2 and 3 select the 32-bit signed add. Lanes never carry into one another.
- R2: Unsigned add (`is_signed_i`=0, `is_sub_i`=0). When the lane sum exceeds the lane range, the lane becomes all ones (0xFF or 0xFFFF). Otherwise it is the exact sum.
- R3: Unsigned subtract (`is_signed_i`=0, `is_sub_i`=1). The lane is zero when the first operand is less than or equal to the second, and the exact difference otherwise. Only a strictly smaller first operand counts as a clamp.
- R4: Signed add (`is_signed_i`=1, `is_sub_i`=0). On two's-complement overflow the lane becomes 0x80/0x8000 if the first operand is negative, and 0x7F/0x7FFF otherwise. Without overflow it is the exact sum.
- R5: Signed subtract (`is_signed_i`=1, `is_sub_i`=1). On overflow the lane clamps by the same rule on the first operand's sign. Without overflow it is the exact difference.
- R6: In word mode the result is the 32-bit sum modulo 2^32, with no clamping. An overflow event is raised when both operands share a sign and the sum's sign differs. `is_signed_i` and `is_sub_i` have no effect, and `lane_sat_o` reads zero.
- R7: Result, clamp vector and `out_valid_o` are registered at the edge that samples `in_valid_i`=1. While `in_valid_i`=0, `out_valid_o` goes low the next cycle and `result_o`/`lane_sat_o` keep their last values.
- R8: Bit k of `lane_sat_o` is set exactly when lane k clamped. In 16-bit mode bits 3:2 read zero.
- R9: `q_flag_o` is set at the edge of any valid operation with a lane clamp or a word overflow. It stays set until `q_clear_i` is sampled high. A clear and a new event in the same cycle leave the flag set.
- R10: A synchronous active-high `rst` drives `out_valid_o`, `result_o`, `lane_sat_o` and `q_flag_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation strobe |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| size_sel_i | input | 2 | 0: 8-bit lanes, 1: 16-bit lanes, 2/3: 32-bit signed add |
| is_signed_i | input | 1 | 1 selects signed clamping |
| is_sub_i | input | 1 | 1 selects subtraction |
| q_clear_i | input | 1 | Clears the sticky overflow flag |
| out_valid_o | output | 1 | Result valid, one cycle after `in_valid_i` |
| result_o | output | 32 | Packed result |
| lane_sat_o | output | 4 | Per-lane clamp indication |
| q_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit word and a narrow lane of 8 bits. At these values both lane layouts and the word path are active in one instance, so every lane shares its boundary bits with a lane of the other size. Directed vectors reach the exact clamp boundaries in both sizes: all-ones plus one, equal-operand subtraction, 0x7F+1, 0x80-1, and the 0x7FFFFFFF and 0x80000000 word extremes. A seeded random mix then covers all sizes, both signednesses and both operations. Expected lanes come from wide integer arithmetic with explicit range clamping. The flag is tracked from clear and set events, including a clear in the same cycle as a clamp.

// File: rtl/psat_pkg.sv
package psat_pkg;

    localparam int DEF_WORD_W = 32;
    localparam int DEF_NARROW_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } size_e;

    typedef struct packed {
        size_e size;
        logic  is_signed;
        logic  is_sub;
    } op_ctrl_t;

    function automatic logic is_word_mode(input size_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG  = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] sum, dif;
    logic         u_wrap, u_under, s_ovf_add, s_ovf_sub;
    logic [W-1:0] s_clamp;

    always_comb begin
        sum       = a_i + b_i;
        dif       = a_i - b_i;
        u_wrap    = sum < a_i;
        u_under   = a_i < b_i;
        s_ovf_add = ~(a_i[W-1] ^ b_i[W-1]) & (sum[W-1] ^ a_i[W-1]);
        s_ovf_sub =  (a_i[W-1] ^ b_i[W-1]) & (dif[W-1] ^ a_i[W-1]);
        s_clamp   = a_i[W-1] ? MIN_NEG : MAX_POS;
        unique case ({signed_i, sub_i})
            2'b00: begin sat_o = u_wrap;    y_o = u_wrap  ? ALL_ONES : sum; end
            2'b01: begin sat_o = u_under;   y_o = u_under ? '0       : dif; end
            2'b10: begin sat_o = s_ovf_add; y_o = s_ovf_add ? s_clamp : sum; end
            default: begin sat_o = s_ovf_sub; y_o = s_ovf_sub ? s_clamp : dif; end
        endcase
    end

    // Lane-level guards
    always_comb begin
        if (!signed_i && !sub_i)
            assert_uadd_floor_R2: assert (y_o >= a_i);
        if (!signed_i && sub_i)
            assert_usub_ceiling_R3: assert (y_o <= a_i);
        if (signed_i && !sub_i && sat_o)
            assert_sadd_clamp_R4: assert (y_o[W-1] == a_i[W-1] && (y_o == MAX_POS || y_o == MIN_NEG));
        if (signed_i && sub_i && sat_o)
            assert_ssub_clamp_R5: assert (y_o[W-1] == a_i[W-1] && (y_o == MAX_POS || y_o == MIN_NEG));
    end

endmodule

// File: rtl/psat_word_add.sv
module psat_word_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    always_comb begin
        sum_o = a_i + b_i;
        ovf_o = ~(a_i[W-1] ^ b_i[W-1]) & (sum_o[W-1] ^ a_i[W-1]);
    end

    always_comb begin
        if (ovf_o)
            assert_word_ovf_sign_R6: assert (a_i[W-1] == b_i[W-1] && sum_o[W-1] != b_i[W-1]);
    end

endmodule

// File: rtl/psat_unit.sv
module psat_unit
    import psat_pkg::*;
#(
    parameter int DATA_W   = DEF_WORD_W,
    parameter int NARROW_W = DEF_NARROW_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid_i,
    input  logic [DATA_W-1:0]            opa_i,
    input  logic [DATA_W-1:0]            opb_i,
    input  logic [1:0]                   size_sel_i,
    input  logic                         is_signed_i,
    input  logic                         is_sub_i,
    input  logic                         q_clear_i,
    output logic                         out_valid_o,
    output logic [DATA_W-1:0]            result_o,
    output logic [DATA_W/NARROW_W-1:0]   lane_sat_o,
    output logic                         q_flag_o
);
    localparam int WIDE_W = 2 * NARROW_W;
    localparam int N_NAR  = DATA_W / NARROW_W;
    localparam int N_WID  = DATA_W / WIDE_W;

    op_ctrl_t ctrl;
    assign ctrl = '{size: size_e'(size_sel_i), is_signed: is_signed_i, is_sub: is_sub_i};

    logic [DATA_W-1:0] nar_y, wid_y, word_y;
    logic [N_NAR-1:0]  nar_sat;
    logic [N_WID-1:0]  wid_sat;
    logic              word_ovf;

    for (genvar i = 0; i < N_NAR; i++) begin : g_nar
        psat_lane #(.W(NARROW_W)) u_lane (
            .a_i      (opa_i[i*NARROW_W +: NARROW_W]),
            .b_i      (opb_i[i*NARROW_W +: NARROW_W]),
            .signed_i (ctrl.is_signed),
            .sub_i    (ctrl.is_sub),
            .y_o      (nar_y[i*NARROW_W +: NARROW_W]),
            .sat_o    (nar_sat[i])
        );
    end

    for (genvar j = 0; j < N_WID; j++) begin : g_wid
        psat_lane #(.W(WIDE_W)) u_lane (
            .a_i      (opa_i[j*WIDE_W +: WIDE_W]),
            .b_i      (opb_i[j*WIDE_W +: WIDE_W]),
            .signed_i (ctrl.is_signed),
            .sub_i    (ctrl.is_sub),
            .y_o      (wid_y[j*WIDE_W +: WIDE_W]),
            .sat_o    (wid_sat[j])
        );
    end

    psat_word_add #(.W(DATA_W)) u_word (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sum_o (word_y),
        .ovf_o (word_ovf)
    );

    logic [DATA_W-1:0] nxt_res;
    logic [N_NAR-1:0]  nxt_sat;
    logic              nxt_evt;

    always_comb begin
        nxt_sat = '0;
        if (is_word_mode(ctrl.size)) begin
            nxt_res = word_y;
        end else if (ctrl.size == SZ_HALF) begin
            nxt_res = wid_y;
            nxt_sat[N_WID-1:0] = wid_sat;
        end else begin
            nxt_res = nar_y;
            nxt_sat = nar_sat;
        end
        nxt_evt = (|nxt_sat) | (is_word_mode(ctrl.size) & word_ovf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            lane_sat_o  <= '0;
            q_flag_o    <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                result_o   <= nxt_res;
                lane_sat_o <= nxt_sat;
            end
            q_flag_o <= (q_flag_o & ~q_clear_i) | (in_valid_i & nxt_evt);
        end
    end

    assert_vld_follow_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);
    assert_vld_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !out_valid_o);
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> ($stable(result_o) && $stable(lane_sat_o)));
    assert_half_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && size_sel_i == SZ_HALF) |=> (lane_sat_o[N_NAR-1:N_WID] == '0));
    assert_word_nosat_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && size_sel_i[1]) |=> (lane_sat_o == '0));
    assert_q_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (q_flag_o && !q_clear_i) |=> q_flag_o);
    assert_q_set_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && (|nar_sat) && size_sel_i == SZ_BYTE) |=> q_flag_o);
    assert_q_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (q_clear_i && !in_valid_i) |=> !q_flag_o);

endmodule

// File: tb/psat_unit_bench.sv
module psat_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] opa, opb;
    logic [1:0]  size_sel;
    logic        is_signed, is_sub, q_clear;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  lane_sat;
    logic        q_flag;

    int checks = 0;
    int fails  = 0;
    bit q_model = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psat_unit u_psat_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid),
        .opa_i       (opa),
        .opb_i       (opb),
        .size_sel_i  (size_sel),
        .is_signed_i (is_signed),
        .is_sub_i    (is_sub),
        .q_clear_i   (q_clear),
        .out_valid_o (out_valid),
        .result_o    (result),
        .lane_sat_o  (lane_sat),
        .q_flag_o    (q_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: wide-integer arithmetic clamped to the lane range
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] sz, input bit sg, input bit sb,
                                  output logic [31:0] y, output logic [3:0] st, output bit qe);
        y = '0; st = '0; qe = 1'b0;
        if (sz[1]) begin
            longint s;
            s  = longint'($signed(a)) + longint'($signed(b));
            y  = a + b;
            qe = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else begin
            int w;
            int n;
            longint mask;
            w = sz[0] ? 16 : 8;
            n = 32 / w;
            mask = (64'sd1 <<< w) - 1;
            for (int k = 0; k < n; k++) begin
                longint ua, ub, r, lo, hi;
                ua = (longint'(a) >>> (k*w)) & mask;
                ub = (longint'(b) >>> (k*w)) & mask;
                if (sg) begin
                    if (ua >= (64'sd1 <<< (w-1))) ua = ua - (64'sd1 <<< w);
                    if (ub >= (64'sd1 <<< (w-1))) ub = ub - (64'sd1 <<< w);
                    lo = -(64'sd1 <<< (w-1));
                    hi = (64'sd1 <<< (w-1)) - 1;
                end else begin
                    lo = 0;
                    hi = mask;
                end
                r = sb ? ua - ub : ua + ub;
                if (r > hi) begin r = hi; st[k] = 1'b1; end
                else if (r < lo) begin r = lo; st[k] = 1'b1; end
                y = y | (32'(r & mask) << (k*w));
            end
            qe = |st;
        end
    endfunction

    function automatic string req_of(input logic [1:0] sz, input bit sg, input bit sb);
        if (sz[1]) return "R6";
        if (!sg && !sb) return "R2";
        if (!sg && sb) return "R3";
        if (sg && !sb) return "R4";
        return "R5";
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] sz,
                          input bit sg, input bit sb, input bit clr, input string tag);
        logic [31:0] ey;
        logic [3:0]  es;
        bit          eq;
        string       t;
        @(negedge clk);
        opa = a; opb = b; size_sel = sz; is_signed = sg; is_sub = sb;
        q_clear = clr; in_valid = 1'b1;
        model(a, b, sz, sg, sb, ey, es, eq);
        q_model = (q_model & ~clr) | eq;
        t = (tag == "") ? req_of(sz, sg, sb) : tag;
        @(posedge clk);
        #1;
        check({t, " result"}, result, ey);
        check("R8 lane_sat", {28'd0, lane_sat}, {28'd0, es});
        check("R7 out_valid", {31'd0, out_valid}, 32'd1);
        check("R9 q_flag", {31'd0, q_flag}, {31'd0, q_model});
    endtask

    task automatic idle(input bit clr);
        logic [31:0] r0;
        logic [3:0]  s0;
        r0 = result; s0 = lane_sat;
        @(negedge clk);
        in_valid = 1'b0; q_clear = clr;
        opa = 32'h7F7F_7F7F; opb = 32'h0101_0101; size_sel = 2'd0; is_signed = 1'b1; is_sub = 1'b0;
        q_model = q_model & ~clr;
        @(posedge clk);
        #1;
        check("R7 hold result", result, r0);
        check("R7 hold lane_sat", {28'd0, lane_sat}, {28'd0, s0});
        check("R7 out_valid low", {31'd0, out_valid}, 32'd0);
        check("R9 q_flag idle", {31'd0, q_flag}, {31'd0, q_model});
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0; size_sel = '0;
        is_signed = 1'b0; is_sub = 1'b0; q_clear = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 out_valid", {31'd0, out_valid}, 32'd0);
        check("R10 result", result, 32'd0);
        check("R10 lane_sat", {28'd0, lane_sat}, 32'd0);
        check("R10 q_flag", {31'd0, q_flag}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1: lanes isolated, no carry between byte lanes or halfword lanes
        run_op(32'h01FF_00FF, 32'h0001_0001, 2'd0, 1'b0, 1'b0, 1'b0, "R1");
        idle(1'b1);
        run_op(32'h00FF_FFFF, 32'h0001_0001, 2'd1, 1'b0, 1'b0, 1'b0, "R1");
        idle(1'b1);
        // R2 unsigned add wrap to all ones
        run_op(32'hF010_80FF, 32'h2010_8001, 2'd0, 1'b0, 1'b0, 1'b0, "R2");
        run_op(32'hFFFF_1234, 32'h0001_0001, 2'd1, 1'b0, 1'b0, 1'b0, "R2");
        idle(1'b1);
        // R3 unsigned subtract: equal operands give zero without clamp
        run_op(32'h5555_0310, 32'h5555_0420, 2'd0, 1'b0, 1'b1, 1'b0, "R3");
        run_op(32'h1234_0001, 32'h1234_0002, 2'd1, 1'b0, 1'b1, 1'b0, "R3");
        idle(1'b1);
        // R4 signed add both directions
        run_op(32'h7F80_7F10, 32'h01FF_0010, 2'd0, 1'b1, 1'b0, 1'b0, "R4");
        run_op(32'h7FFF_8000, 32'h0001_FFFF, 2'd1, 1'b1, 1'b0, 1'b0, "R4");
        idle(1'b1);
        // R5 signed subtract both directions
        run_op(32'h807F_0080, 32'h01FF_0101, 2'd0, 1'b1, 1'b1, 1'b0, "R5");
        run_op(32'h8000_7FFF, 32'h0001_FFFF, 2'd1, 1'b1, 1'b1, 1'b0, "R5");
        idle(1'b1);
        // R6 word add: flags ignored, wraps, overflow sets flag
        run_op(32'h7FFF_FFFF, 32'h0000_0001, 2'd2, 1'b0, 1'b1, 1'b0, "R6");
        idle(1'b1);
        run_op(32'h8000_0000, 32'h8000_0000, 2'd3, 1'b1, 1'b0, 1'b0, "R6");
        idle(1'b1);
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 2'd2, 1'b1, 1'b1, 1'b0, "R6");
        // R9 sticky, then clear together with an event keeps it set
        run_op(32'h0000_00FF, 32'h0000_0001, 2'd0, 1'b0, 1'b0, 1'b0, "R9");
        run_op(32'h0000_0001, 32'h0000_0001, 2'd0, 1'b0, 1'b0, 1'b0, "R9");
        idle(1'b0);
        run_op(32'h0000_00FF, 32'h0000_0001, 2'd0, 1'b0, 1'b0, 1'b1, "R9");
        idle(1'b1);
        run_op(32'h0000_0001, 32'h0000_0001, 2'd1, 1'b0, 1'b0, 1'b1, "R9");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, b;
            a = $urandom();
            b = $urandom();
            if ((n % 7) == 0) b = a;
            run_op(a, b, 2'($urandom_range(3, 0)), 1'($urandom()), 1'($urandom()),
                   ($urandom_range(9, 0) == 0), "");
            if ((n % 37) == 0) idle(1'($urandom()));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule